// File: doc/BRIEF.md
# Stride Stream Prefetcher

This block sits beside a data cache and watches the demand accesses that reach it, one block address per cycle at most. From that stream it produces at most one prefetch request per cycle, carried on a valid/ready output pair. The cache or memory side takes the request when it can.

The prefetcher has two selectable behaviours. In next-block mode, every demand access asks for the 64-byte block that directly follows the one accessed. In stream mode, the block learns a constant address step between successive accesses. Once it trusts that step, it asks for the block four steps ahead. A small saturating confidence counter lets a stream survive one stray access. A prefetch whose target leaves the 4 KB page of the access that caused it is dropped. An address equal to the last one issued is never requested a second time. The output holds one request only, and a newer request overwrites one that is still waiting.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is asserted and after it is released, `pf_valid` is low until a demand access produces a prefetch.
- R2: With `mode_stream` = 0, a demand access at address A makes `pf_valid` high with `pf_addr` = A + 64 on the clock edge that follows the access.
- R3: In both modes, no prefetch is produced when bits [31:12] of the target differ from bits [31:12] of the triggering address.
- R4: With `mode_stream` = 1, a prefetch is produced only when the current nonzero delta (address minus previous address) equals the candidate stride. The first such repetition is enough: three accesses at a constant step give a prefetch on the third. The target is A + 4 × delta.
- R5: Deltas are two's complement modulo 2^32, so descending streams are learned and prefetched below the access.
- R6: Confidence is a 2-bit saturating count. A matching delta raises it. A mismatching delta lowers it by one when it is 2 or more and keeps the candidate. Otherwise the mismatching delta becomes the new candidate with confidence 1. A mismatching access never prefetches.
- R7: A zero delta never produces a stream prefetch.
- R8: A target equal to the last address loaded into the output is not loaded again.
- R9: While `pf_valid` is high and `pf_ready` is low, the request stays stable until a newer prefetch replaces it. The newer one overwrites it with no queueing.
- R10: `pf_valid` falls one cycle after a handshake (`pf_valid` and `pf_ready` high) that has no new prefetch alongside it. It rises only in the cycle after a demand access.
- R11: Stride learning runs in both modes, so a stream trained in next-block mode prefetches as soon as the mode switches to stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_stream | input | 1 | 0 selects next-block mode, 1 selects stride stream mode |
| dmd_valid | input | 1 | A demand access is present this cycle |
| dmd_addr | input | 32 | Byte address of the demand access |
| pf_ready | input | 1 | The receiver accepts the prefetch request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | 32 | Byte address of the offered prefetch |

## Verification
The hardest state to reach from the ports is a confidence level of 2 or 3 at the moment a stray delta arrives, because only then is the candidate kept rather than replaced. The stimulus reaches it by running a constant-step stream for several accesses and then inserting a jump into another page. One more access at the old step must then yield a prefetch at once. Random bursts of mixed steps, with zero and negative steps, random mode and random back-pressure, are compared on every cycle with a behavioural model. This also covers replacement of a pending request and suppression of duplicates.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    PF_MODE_NEXT   = 1'b0,
    PF_MODE_STREAM = 1'b1
  } pf_mode_e;

  localparam int unsigned PF_CONF_W = 2;
endpackage

// File: rtl/pf_stride_train.sv
module pf_stride_train #(
  parameter int unsigned AW      = 32,
  parameter int unsigned CONF_W  = pf_pkg::PF_CONF_W,
  parameter int unsigned CONFIRM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dmd_valid,
  input  logic [AW-1:0] dmd_addr,
  output logic          stride_hit,
  output logic [AW-1:0] stride
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] CONF_ONE = {{(CONF_W-1){1'b0}}, 1'b1};
  localparam logic [CONF_W:0]   CONF_THR = (CONF_W+1)'(CONFIRM);

  logic [AW-1:0]     last_q, last_d;
  logic              have_q, have_d;
  logic [AW-1:0]     cand_q, cand_d;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic [AW-1:0]     delta;
  logic              match;
  logic              upd_en;

  assign delta  = dmd_addr - last_q;
  assign match  = have_q && (delta != '0) && (delta == cand_q);
  assign upd_en = dmd_valid;

  always_comb begin
    last_d = last_q;
    have_d = have_q;
    cand_d = cand_q;
    conf_d = conf_q;
    if (dmd_valid) begin
      last_d = dmd_addr;
      have_d = 1'b1;
      if (have_q) begin
        if (match) begin
          conf_d = (conf_q == CONF_MAX) ? conf_q : conf_q + CONF_ONE;
        end else if (conf_q >= 2) begin
          conf_d = conf_q - CONF_ONE;
        end else begin
          cand_d = delta;
          conf_d = CONF_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
      cand_q <= '0;
      conf_q <= '0;
    end else if (upd_en) begin
      last_q <= last_d;
      have_q <= have_d;
      cand_q <= cand_d;
      conf_q <= conf_d;
    end
  end

  assign stride_hit = dmd_valid && match && (({1'b0, conf_q} + 1'b1) >= CONF_THR);
  assign stride     = delta;
endmodule

// File: rtl/pf_target_sel.sv
module pf_target_sel #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BLK_BYTES  = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned LOOKAHEAD  = 4
) (
  input  pf_pkg::pf_mode_e mode,
  input  logic             dmd_valid,
  input  logic [AW-1:0]    dmd_addr,
  input  logic             stride_hit,
  input  logic [AW-1:0]    stride,
  output logic             cand_valid,
  output logic [AW-1:0]    cand_addr
);
  localparam logic [AW-1:0] BLK_STEP = AW'(BLK_BYTES);
  localparam logic [AW-1:0] LA_MULT  = AW'(LOOKAHEAD);

  logic [AW-1:0] tgt;
  logic          want;
  logic          in_page;

  always_comb begin
    if (mode == pf_pkg::PF_MODE_STREAM) begin
      tgt  = dmd_addr + (stride * LA_MULT);
      want = stride_hit;
    end else begin
      tgt  = dmd_addr + BLK_STEP;
      want = dmd_valid;
    end
  end

  assign in_page    = (tgt[AW-1:PAGE_SHIFT] == dmd_addr[AW-1:PAGE_SHIFT]);
  assign cand_valid = want && in_page;
  assign cand_addr  = tgt;
endmodule

// File: rtl/pf_out_slot.sv
module pf_out_slot #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_valid,
  input  logic [AW-1:0] cand_addr,
  input  logic          pf_ready,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr
);
  logic          iss_v_q;
  logic [AW-1:0] iss_q;
  logic          load;
  logic          valid_d;
  logic          valid_en;

  assign load     = cand_valid && !(iss_v_q && (iss_q == cand_addr));
  assign valid_d  = load;
  assign valid_en = load || pf_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
    end else if (valid_en) begin
      pf_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_addr <= '0;
      iss_q   <= '0;
      iss_v_q <= 1'b0;
    end else if (load) begin
      pf_addr <= cand_addr;
      iss_q   <= cand_addr;
      iss_v_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BLK_BYTES  = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned LOOKAHEAD  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_stream,
  input  logic          dmd_valid,
  input  logic [AW-1:0] dmd_addr,
  input  logic          pf_ready,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr
);
  logic             stride_hit;
  logic [AW-1:0]    stride;
  logic             cand_valid;
  logic [AW-1:0]    cand_addr;
  pf_pkg::pf_mode_e mode;

  assign mode = mode_stream ? pf_pkg::PF_MODE_STREAM : pf_pkg::PF_MODE_NEXT;

  pf_stride_train #(.AW(AW)) u_train (
    .clk        (clk),
    .rst_n      (rst_n),
    .dmd_valid  (dmd_valid),
    .dmd_addr   (dmd_addr),
    .stride_hit (stride_hit),
    .stride     (stride)
  );

  pf_target_sel #(
    .AW(AW), .BLK_BYTES(BLK_BYTES), .PAGE_SHIFT(PAGE_SHIFT), .LOOKAHEAD(LOOKAHEAD)
  ) u_sel (
    .mode       (mode),
    .dmd_valid  (dmd_valid),
    .dmd_addr   (dmd_addr),
    .stride_hit (stride_hit),
    .stride     (stride),
    .cand_valid (cand_valid),
    .cand_addr  (cand_addr)
  );

  pf_out_slot #(.AW(AW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_addr  (cand_addr),
    .pf_ready   (pf_ready),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BLK_BYTES  = 64,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_stream,
  input logic          dmd_valid,
  input logic [AW-1:0] dmd_addr,
  input logic          pf_ready,
  input logic          pf_valid,
  input logic [AW-1:0] pf_addr
);
  localparam logic [AW-1:0] BLK_STEP = AW'(BLK_BYTES);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !pf_valid); // R1

  AST_NEXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dmd_valid) && !$past(mode_stream) && pf_valid && (pf_addr != $past(pf_addr)))
      |-> (pf_addr == $past(dmd_addr) + BLK_STEP)); // R2

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && (pf_addr != $past(pf_addr)))
      |-> (pf_addr[AW-1:PAGE_SHIFT] == $past(dmd_addr[AW-1:PAGE_SHIFT]))); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !dmd_valid) |=> (pf_valid && $stable(pf_addr))); // R9

  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !dmd_valid) |=> !pf_valid); // R10

  AST_RISE_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(dmd_valid)); // R10
endmodule

bind stride_prefetcher pf_checker #(
  .AW(AW), .BLK_BYTES(BLK_BYTES), .PAGE_SHIFT(PAGE_SHIFT)
) u_pf_checker (
  .clk(clk), .rst_n(rst_n), .mode_stream(mode_stream), .dmd_valid(dmd_valid),
  .dmd_addr(dmd_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/test_stride_prefetcher.sv
module test_stride_prefetcher;
  logic        clk;
  logic        rst_n;
  logic        mode_stream;
  logic        dmd_valid;
  logic [31:0] dmd_addr;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_chk = 0;
  int n_bad = 0;

  stride_prefetcher i_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .mode_stream(mode_stream), .dmd_valid(dmd_valid),
    .dmd_addr(dmd_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_last, m_cand, m_iss, m_pa;
  int          m_conf;
  bit          m_have, m_iv, m_pv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 0; m_cand = 0; m_iss = 0; m_pa = 0;
      m_conf = 0; m_have = 0; m_iv = 0; m_pv = 0;
    end else begin
      logic [31:0] d, t;
      bit hit, cv;
      cv = 0; hit = 0; t = 0;
      if (dmd_valid) begin
        d = dmd_addr - m_last;
        if (m_have) begin
          if (d != 0 && d == m_cand) begin
            hit = 1;
            if (m_conf < 3) m_conf = m_conf + 1;
          end else if (m_conf >= 2) begin
            m_conf = m_conf - 1;
          end else begin
            m_cand = d; m_conf = 1;
          end
        end
        m_last = dmd_addr; m_have = 1;
        if (!mode_stream) begin t = dmd_addr + 32'd64; cv = 1; end
        else if (hit) begin t = dmd_addr + d * 4; cv = 1; end
        if (cv && t[31:12] != dmd_addr[31:12]) cv = 0;
        if (cv && m_iv && m_iss == t) cv = 0;
      end
      if (cv) begin m_pv = 1; m_pa = t; m_iss = t; m_iv = 1; end
      else if (pf_ready) m_pv = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (pf_valid !== m_pv || (m_pv && pf_addr !== m_pa)) begin
        n_bad++;
        $display("FAIL R9 model compare: valid=%0b addr=%h expected valid=%0b addr=%h",
                 pf_valid, pf_addr, m_pv, m_pa);
      end
    end
  end

  task automatic chk(string tag, bit ev, logic [31:0] ea);
    n_chk++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, pf_valid, pf_addr, ev, ea);
    end
  endtask

  task automatic step(bit v, logic [31:0] a);
    @(negedge clk);
    dmd_valid = v;
    dmd_addr  = a;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dmd_valid = 1'b0; dmd_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_stream = 1'b0; dmd_valid = 1'b0; dmd_addr = '0; pf_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 in reset", 0, 0);
    rst_n = 1'b1;
    step(0, 0); step(0, 0);
    chk("R1 after reset", 0, 0);

    // R2 next block
    step(1, 32'h1000); step(0, 0);
    chk("R2 next block", 1, 32'h1040);
    step(0, 0);
    chk("R10 drop after take", 0, 0);
    // R3 page crossing in next-block mode
    step(1, 32'h1FC0); step(0, 0);
    chk("R3 next block crosses page", 0, 0);
    // R8 duplicate suppression
    step(1, 32'h3000); step(0, 0);
    chk("R8 first issue", 1, 32'h3040);
    step(1, 32'h3000); step(0, 0);
    chk("R8 repeat suppressed", 0, 0);

    // R4 stride confirmation
    do_reset(); mode_stream = 1'b1;
    step(1, 32'h100); step(1, 32'h300); step(0, 0);
    chk("R4 one delta not enough", 0, 0);
    step(1, 32'h500); step(0, 0);
    chk("R4 stride confirmed", 1, 32'hD00);
    // R3 stream crossing
    do_reset();
    step(1, 32'h800); step(1, 32'hA00); step(1, 32'hC00); step(0, 0);
    chk("R3 stream crosses page", 0, 0);
    // R5 descending
    do_reset();
    step(1, 32'h2F00); step(1, 32'h2E00); step(1, 32'h2D00); step(0, 0);
    chk("R5 descending stride", 1, 32'h2900);
    // R6 candidate kept at high confidence
    do_reset();
    step(1, 32'h100); step(1, 32'h140); step(1, 32'h180); step(1, 32'h1C0); step(0, 0);
    chk("R6 conf build", 1, 32'h2C0);
    step(1, 32'h1000); step(0, 0);
    chk("R6 mismatch no prefetch", 0, 0);
    step(1, 32'h1040); step(0, 0);
    chk("R6 candidate kept", 1, 32'h1140);
    // R6 candidate replaced at low confidence
    do_reset();
    step(1, 32'h100); step(1, 32'h140); step(1, 32'h200); step(0, 0);
    chk("R6 replace no prefetch", 0, 0);
    step(1, 32'h2C0); step(0, 0);
    chk("R6 new candidate", 1, 32'h5C0);
    // R7 zero delta
    do_reset();
    step(1, 32'h5000); step(1, 32'h5000); step(1, 32'h5000); step(0, 0);
    chk("R7 zero delta", 0, 0);
    // R11 training in next-block mode
    do_reset(); mode_stream = 1'b0;
    step(1, 32'h6000); step(1, 32'h6080); step(1, 32'h6100);
    @(negedge clk); mode_stream = 1'b1; dmd_valid = 1'b1; dmd_addr = 32'h6180;
    step(0, 0);
    chk("R11 trained across modes", 1, 32'h6380);
    // R9 stall and replace
    do_reset(); mode_stream = 1'b0; pf_ready = 1'b0;
    step(1, 32'h4000); step(0, 0);
    chk("R9 offered", 1, 32'h4040);
    step(0, 0); step(0, 0);
    chk("R9 held under stall", 1, 32'h4040);
    step(1, 32'h4100); step(0, 0);
    chk("R9 newest replaces", 1, 32'h4140);
    @(negedge clk); pf_ready = 1'b1;
    step(0, 0);
    chk("R10 taken then dropped", 0, 0);

    // random bursts, checked against the model every cycle
    do_reset();
    for (int b = 0; b < 400; b++) begin
      logic [31:0] base, st;
      int len;
      mode_stream = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 5))
        0: st = 32'h40;
        1: st = 32'h80;
        2: st = 32'hFFFF_FFC0;
        3: st = 32'h200;
        4: st = 32'h0;
        default: st = {$urandom_range(0, 63), 6'b0};
      endcase
      base = {$urandom_range(0, 15), 6'b0, $urandom_range(0, 63), 6'b0};
      len  = $urandom_range(2, 8);
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        pf_ready  = ($urandom_range(0, 3) != 0);
        dmd_valid = ($urandom_range(0, 4) != 0);
        dmd_addr  = base;
        if (dmd_valid) base = base + st;
      end
    end
    step(0, 0); step(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule